// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a synthesizable on-chip model of a pipelined synchronous static RAM. Each word has four byte lanes. A lane holds eight data bits and one parity bit, so a word is 36 bits wide. The rising clock edge captures the address, the write data, the three chip enables and the write controls. The next edge carries out the captured operation: it writes the enabled lanes into the array, or it loads the addressed word into an output register. A write has two sources. An active-low global write stores the whole word. Otherwise a byte-write enable combines with an active-low enable for each lane. A cycle that enables no lane is a read.

The address and the chip-select state are captured only in cycles that assert the address-load strobe. Between loads, both keep their last captured values. An active-high snooze input freezes the block without waiting for a clock edge: the array contents, the pipeline registers and the output register are all held. An active-low output enable, which also acts without a clock, decides whether the read port is driven. Inside a chip the port cannot float, so an undriven port is shown by a low drive flag and an all-zero data value.

Top module: `sync_sram_pipe`

## Requirements
- R1: The rising edge captures the inputs. A read captured at edge N updates `rd_data` at edge N+1. `rd_data` changes only when a read completes.
- R2: While `wr_all_n` is low at the capturing edge, the block stores all four lanes of `wr_data`, parity bits included, whatever `byte_wr_n` and `lane_wr_n` are.
- R3: While `wr_all_n` is high, lane i is written only if `byte_wr_n` is low and `lane_wr_n[i]` is low. Lane i occupies bits [9i+7:9i] for data and bit 9i+8 for parity. Lanes that are not written keep their old contents.
- R4: A selected cycle that enables no lane is a read. This covers `byte_wr_n` high whatever the lane enables are, and `byte_wr_n` low with every `lane_wr_n` bit high.
- R5: The block is selected only when `en_pri_n` is low, `en_sec` is high and `en_ter_n` is low. A deselected cycle writes nothing and leaves `rd_data` unchanged.
- R6: The address and the three enables are captured only at an edge where `adr_load` is high. At other edges the previous address and select state are used.
- R7: While `snooze` is high, every other input is ignored. The array, the captured address, the select state, any pending operation and `rd_data` are all kept.
- R8: `rd_drive` is high exactly when `oe_n` is low and `snooze` is low. While `rd_drive` is low, `rd_data` reads as all zeros.
- R9: After reset, the output register holds zero and the block is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the control and output registers |
| snooze | input | 1 | Active-high standby that acts without a clock and freezes all state |
| oe_n | input | 1 | Active-low read-port drive enable, acts without a clock |
| adr_load | input | 1 | Strobe that captures a new address and the chip enables |
| addr | input | ADDR_W | Word address |
| en_pri_n | input | 1 | Primary chip enable, active low |
| en_sec | input | 1 | Secondary chip enable, active high |
| en_ter_n | input | 1 | Tertiary chip enable, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| wr_data | input | WORD_W | Write data, packed lane by lane |
| rd_data | output | WORD_W | Read data from the output register, zero when not driven |
| rd_drive | output | 1 | High while the read port is driven |

## Verification
The hardest case to reach from the ports is a snooze period that arrives while the block is selected and an address is held. A write presented during snooze must then leave no trace: no change to the array, the address or the select state. The stimulus first leaves the block selected on a known address with only repeat reads in flight. It then raises snooze and presents a global write to a different address with a fresh load strobe. Snooze is dropped with the load strobe low, so the next read must come from the old address. A later read of the address targeted during snooze confirms that the array still holds its old word.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } ssr_op_e;

   function automatic int lane_width(input int byte_w, input bit parity);
      return byte_w + (parity ? 1 : 0);
   endfunction

endpackage

// File: rtl/ssr_wdec.sv
module ssr_wdec #(
   parameter int LANES = 4
) (
   input  logic             wr_all_n,
   input  logic             byte_wr_n,
   input  logic [LANES-1:0] lane_wr_n,
   output logic [LANES-1:0] strobe
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // global write overrides; otherwise byte enable gates each lane enable
      assign strobe[i] = ~wr_all_n | (~byte_wr_n & ~lane_wr_n[i]);
   end

endmodule

// File: rtl/ssr_front.sv
module ssr_front
   import ssr_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snooze,
   input  logic              adr_load,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en_pri_n,
   input  logic              en_sec,
   input  logic              en_ter_n,
   input  logic [LANES-1:0]  strobe,
   input  logic [WORD_W-1:0] wr_data,
   output logic [ADDR_W-1:0] addr_q,
   output logic              sel_q,
   output ssr_op_e           op_q,
   output logic [LANES-1:0]  strb_q,
   output logic [WORD_W-1:0] wd_q
);

   logic sel_now;
   logic sel_eff;
   ssr_op_e op_next;

   assign sel_now = ~en_pri_n & en_sec & ~en_ter_n;
   assign sel_eff = adr_load ? sel_now : sel_q;

   always_comb begin
      if (!sel_eff)        op_next = OP_IDLE;
      else if (|strobe)    op_next = OP_WRITE;
      else                 op_next = OP_READ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         sel_q  <= 1'b0;
      end else if (!snooze && adr_load) begin
         addr_q <= addr;
         sel_q  <= sel_now;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         strb_q <= '0;
         wd_q   <= '0;
      end else if (!snooze) begin
         op_q   <= op_next;
         strb_q <= strobe;
         wd_q   <= wr_data;
      end
   end

endmodule

// File: rtl/ssr_array.sv
module ssr_array
   import ssr_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter bit PARITY = 1'b1,
   localparam int LANE_W = lane_width(BYTE_W, PARITY),
   localparam int WORD_W = LANES * LANE_W,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snooze,
   input  ssr_op_e           op_q,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [LANES-1:0]  strb_q,
   input  logic [WORD_W-1:0] wd_q,
   output logic [WORD_W-1:0] rd_q
);

   logic [WORD_W-1:0] rd_next;
   logic              wr_go;
   logic              rd_go;

   assign wr_go = !snooze && (op_q == OP_WRITE);
   assign rd_go = !snooze && (op_q == OP_READ);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int BASE = i * LANE_W;
      logic [BYTE_W-1:0] dmem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_go && strb_q[i]) dmem[addr_q] <= wd_q[BASE +: BYTE_W];
      end
      assign rd_next[BASE +: BYTE_W] = dmem[addr_q];

      if (PARITY) begin : g_par
         logic pmem [DEPTH];
         always_ff @(posedge clk) begin
            if (wr_go && strb_q[i]) pmem[addr_q] <= wd_q[BASE + BYTE_W];
         end
         assign rd_next[BASE + BYTE_W] = pmem[addr_q];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_go) rd_q <= rd_next;
   end

endmodule

// File: rtl/sync_sram_pipe.sv
module sync_sram_pipe
   import ssr_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter bit PARITY = 1'b1,
   localparam int LANE_W = lane_width(BYTE_W, PARITY),
   localparam int WORD_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snooze,
   input  logic              oe_n,
   input  logic              adr_load,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en_pri_n,
   input  logic              en_sec,
   input  logic              en_ter_n,
   input  logic              wr_all_n,
   input  logic              byte_wr_n,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_drive
);

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("sync_sram_pipe: ADDR_W must be in 1..12");
   end
   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("sync_sram_pipe: LANES must be in 1..16");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("sync_sram_pipe: BYTE_W must be positive");
   end

   logic [LANES-1:0]  strobe;
   logic [ADDR_W-1:0] addr_q;
   logic              sel_q;
   ssr_op_e           op_q;
   logic [LANES-1:0]  strb_q;
   logic [WORD_W-1:0] wd_q;
   logic [WORD_W-1:0] rd_q;

   ssr_wdec #(.LANES(LANES)) u_wdec (
      .wr_all_n  (wr_all_n),
      .byte_wr_n (byte_wr_n),
      .lane_wr_n (lane_wr_n),
      .strobe    (strobe)
   );

   ssr_front #(.ADDR_W(ADDR_W), .LANES(LANES), .WORD_W(WORD_W)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .snooze   (snooze),
      .adr_load (adr_load),
      .addr     (addr),
      .en_pri_n (en_pri_n),
      .en_sec   (en_sec),
      .en_ter_n (en_ter_n),
      .strobe   (strobe),
      .wr_data  (wr_data),
      .addr_q   (addr_q),
      .sel_q    (sel_q),
      .op_q     (op_q),
      .strb_q   (strb_q),
      .wd_q     (wd_q)
   );

   ssr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W), .PARITY(PARITY)) u_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .snooze (snooze),
      .op_q   (op_q),
      .addr_q (addr_q),
      .strb_q (strb_q),
      .wd_q   (wd_q),
      .rd_q   (rd_q)
   );

   // drive gating acts immediately on oe_n and snooze
   assign rd_drive = ~oe_n & ~snooze;
   assign rd_data  = rd_drive ? rd_q : '0;

endmodule

// File: rtl/sync_sram_pipe_chk.sv
module sync_sram_pipe_chk
   import ssr_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int WORD_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              snooze,
   input logic              adr_load,
   input logic              wr_all_n,
   input logic [ADDR_W-1:0] addr_q,
   input logic              sel_q,
   input ssr_op_e           op_q,
   input logic [LANES-1:0]  strb_q,
   input logic [WORD_W-1:0] rd_q,
   input logic [WORD_W-1:0] rd_data,
   input logic              rd_drive
);

   a_r1_out_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != OP_READ) |=> $stable(rd_q));

   a_r2_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_all_n && !snooze) |=> (&strb_q));

   a_r5_idle_when_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_q && !adr_load && !snooze) |=> (op_q == OP_IDLE));

   a_r6_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!adr_load && !snooze) |=> ($stable(sel_q) && $stable(addr_q)));

   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      snooze |=> ($stable(rd_q) && $stable(addr_q) && $stable(sel_q) && $stable(op_q)));

   a_r8_off_in_snooze: assert property (@(posedge clk) disable iff (!rst_n)
      snooze |-> !rd_drive);

   a_r8_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_drive |-> (rd_data == '0));

endmodule

bind sync_sram_pipe sync_sram_pipe_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .snooze   (snooze),
   .adr_load (adr_load),
   .wr_all_n (wr_all_n),
   .addr_q   (addr_q),
   .sel_q    (sel_q),
   .op_q     (op_q),
   .strb_q   (strb_q),
   .rd_q     (rd_q),
   .rd_data  (rd_data),
   .rd_drive (rd_drive)
);

// File: tb/sync_sram_pipe_bench.sv
`timescale 1ns/1ps
module sync_sram_pipe_bench;

   localparam int AW = 6;
   localparam int NL = 4;
   localparam int WW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          snooze = 1'b0;
   logic          oe_n = 1'b0;
   logic          adr_load = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          en_pri_n = 1'b1;
   logic          en_sec = 1'b0;
   logic          en_ter_n = 1'b1;
   logic          wr_all_n = 1'b1;
   logic          byte_wr_n = 1'b1;
   logic [NL-1:0] lane_wr_n = '1;
   logic [WW-1:0] wr_data = '0;
   logic [WW-1:0] rd_data;
   logic          rd_drive;

   always #4 clk = ~clk;

   sync_sram_pipe u_sync_sram_pipe (
      .clk(clk), .rst_n(rst_n), .snooze(snooze), .oe_n(oe_n),
      .adr_load(adr_load), .addr(addr), .en_pri_n(en_pri_n), .en_sec(en_sec),
      .en_ter_n(en_ter_n), .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n),
      .lane_wr_n(lane_wr_n), .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   // reference model state
   logic [WW-1:0] ref_mem [1<<AW];
   logic [AW-1:0] m_addr = '0;
   bit            m_sel = 1'b0;
   logic [WW-1:0] m_q = '0;

   int            q_due [$];
   logic [WW-1:0] q_exp [$];
   string         q_tag [$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compare the output register against queued expectations
   always @(negedge clk) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
         chk(q_tag[0], rd_data, q_exp[0]);
         void'(q_due.pop_front());
         void'(q_exp.pop_front());
         void'(q_tag.pop_front());
      end
   end

   function automatic logic [WW-1:0] pat(input int k);
      return (WW'(k) * 36'h0_9E37_79B9) ^ 36'hA_5A5A_5A5A;
   endfunction

   task automatic op(input string tag, input bit ld, input logic [AW-1:0] a,
                     input bit c1n, input bit c2, input bit c3n,
                     input bit gwn, input bit bwn, input logic [NL-1:0] ln,
                     input logic [WW-1:0] d);
      bit sel;
      logic [NL-1:0] strb;
      @(negedge clk);
      adr_load = ld; addr = a; en_pri_n = c1n; en_sec = c2; en_ter_n = c3n;
      wr_all_n = gwn; byte_wr_n = bwn; lane_wr_n = ln; wr_data = d;
      sel = ld ? (!c1n && c2 && !c3n) : m_sel;
      if (ld) begin
         m_sel  = sel;
         m_addr = a;
      end
      strb = !gwn ? '1 : (!bwn ? ~ln : '0);
      if (sel && strb != '0) begin
         for (int i = 0; i < NL; i++)
            if (strb[i]) ref_mem[m_addr][i*9 +: 9] = d[i*9 +: 9];
      end else if (sel) begin
         m_q = ref_mem[m_addr];
      end
      q_due.push_back(cyc + 2);
      q_exp.push_back(m_q);
      q_tag.push_back(tag);
   endtask

   task automatic rd(input string tag, input logic [AW-1:0] a);
      op(tag, 1, a, 0, 1, 0, 1, 1, '1, pat(99));
   endtask

   task automatic drain();
      while (q_due.size() > 0) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < (1<<AW); i++) ref_mem[i] = 'x;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 reset rd_data", rd_data, '0);
      chk("R9 reset rd_drive", WW'(rd_drive), WW'(1));
      rst_n = 1'b1;

      // R2: global write with byte enables inactive
      for (int k = 0; k < 8; k++) op("R2 gw fill", 1, AW'(k), 0, 1, 0, 0, 1, '1, pat(k));
      // R1: read back, one cycle pipeline
      for (int k = 0; k < 8; k++) rd("R1 read back", AW'(k));
      // R2: global write overrides per-lane selection
      op("R2 gw override", 1, 6'd10, 0, 1, 0, 0, 0, 4'b1110, pat(20));
      op("R2 gw override b", 1, 6'd11, 0, 1, 0, 0, 1, 4'b0000, pat(21));
      rd("R2 read gw 10", 6'd10);
      rd("R2 read gw 11", 6'd11);
      // R3: single-lane writes, parity follows lane
      op("R3 base", 1, 6'd3, 0, 1, 0, 0, 1, '1, 36'h0_0000_0000);
      for (int i = 0; i < NL; i++) begin
         op("R3 lane write", 1, 6'd3, 0, 1, 0, 1, 0, ~(NL'(1) << i), 36'hF_FFFF_FFFF);
         rd("R3 lane read", 6'd3);
      end
      op("R3 two lanes", 1, 6'd4, 0, 1, 0, 1, 0, 4'b1010, pat(33));
      rd("R3 two lanes read", 6'd4);
      // R4: no lane enabled means read
      op("R4 bw off lanes on", 1, 6'd5, 0, 1, 0, 1, 1, 4'b0000, pat(44));
      op("R4 bw on lanes off", 1, 6'd6, 0, 1, 0, 1, 0, 4'b1111, pat(45));
      rd("R4 5 unchanged", 6'd5);
      rd("R4 6 unchanged", 6'd6);
      // R5: each enable alone deselects
      op("R5 pri off", 1, 6'd1, 1, 1, 0, 0, 1, '1, pat(50));
      op("R5 sec off", 1, 6'd1, 0, 0, 0, 0, 1, '1, pat(51));
      op("R5 ter off", 1, 6'd1, 0, 1, 1, 0, 1, '1, pat(52));
      op("R5 unselected read", 1, 6'd2, 1, 0, 1, 1, 1, '1, '0);
      rd("R5 word 1 intact", 6'd1);
      // R6: enables and address ignored without load strobe
      rd("R6 load 7", 6'd7);
      op("R6 held read", 0, 6'd0, 1, 0, 1, 1, 1, '1, '0);
      op("R6 held write", 0, 6'd0, 1, 0, 1, 0, 1, '1, pat(60));
      rd("R6 word 7 rewritten", 6'd7);
      rd("R6 word 0 intact", 6'd0);
      op("R6 deselect load", 1, 6'd2, 1, 1, 0, 0, 1, '1, pat(61));
      op("R6 held deselect", 0, 6'd2, 0, 1, 0, 0, 1, '1, pat(62));
      rd("R6 word 2 intact", 6'd2);

      // R7: snooze freezes everything
      rd("R7 pre read", 6'd4);
      op("R7 hold read", 0, 6'd4, 0, 1, 0, 1, 1, '1, '0);
      drain();
      @(negedge clk);
      snooze = 1'b1;
      adr_load = 1'b1; addr = 6'd8; en_pri_n = 1'b0; en_sec = 1'b1; en_ter_n = 1'b0;
      wr_all_n = 1'b0; wr_data = pat(70);
      #1;
      chk("R8 snooze no drive", WW'(rd_drive), WW'(0));
      chk("R8 snooze zero bus", rd_data, '0);
      repeat (3) @(negedge clk);
      adr_load = 1'b0; wr_all_n = 1'b1; en_pri_n = 1'b1; en_sec = 1'b0;
      snooze = 1'b0;
      #1;
      chk("R7 output held", rd_data, m_q);
      op("R7 address kept", 0, 6'd8, 1, 0, 1, 1, 1, '1, '0);
      rd("R7 word 8 untouched", 6'd8);
      drain();

      // R8: output enable gating
      @(negedge clk);
      oe_n = 1'b1;
      #1;
      chk("R8 oe off drive", WW'(rd_drive), WW'(0));
      chk("R8 oe off bus", rd_data, '0);
      oe_n = 1'b0;
      #1;
      chk("R8 oe on bus", rd_data, m_q);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule